// File: doc/BRIEF.md
# Stream-to-AXI Read Bridge

This block lets a DMA engine pull a 32-bit valid/ready data stream into memory through an AXI4 slave port. Each word the stream offers is held in an internal FIFO. The DMA master reads the slave port, and each read beat returns the oldest buffered word. The address is ignored, so the read data always comes from the FIFO in arrival order.

When sixteen or more words are waiting, the block raises a level output. A separate DMA request handshake controller uses this level to start a fixed-type 16-beat read. Once fewer than sixteen words remain, the master can drain the rest with single-beat reads. The block accepts writes so that the port behaves as a complete slave. Each write is answered with OKAY, and its data is thrown away.

The read side carries only one transaction at a time, and so does the write side. Each address channel stays closed until its own transaction has finished.

Top module: `stream_axi_rd_bridge`

## Requirements
- R1: Each sValid/sReady handshake stores one 32-bit word. Read beats return the stored words in the order they were accepted, with none skipped and none repeated.
- R2: A read with arLen = 15 gives exactly 16 beats. The beats carry the next 16 buffered words in order.
- R3: On a 16-beat read, rLast is 0 on beats 1 to 15 and 1 on beat 16.
- R4: Every read beat returns the arId of its own request and rResp = 2'b00 (OKAY).
- R5: A read with arLen = 0 gives one beat with rLast = 1. A series of such reads continues the same word sequence.
- R6: awReady is 1 while the write side is idle. After an address handshake, data beats are accepted until the beat that has wLast = 1. Then one B response follows with bId equal to the accepted awId and bResp = 2'b00.
- R7: burstAvail is 1 exactly when the FIFO holds 16 or more words. It changes in the cycle after the handshake that crosses that level.
- R8: The FIFO holds 64 words. When it is full, sReady is 0 and an offered word is not stored.
- R9: rValid stays 0 while the FIFO is empty during a read. The beat appears once a word has been stored.
- R10: arReady is 0 from the AR handshake until the last beat's R handshake. awReady is 0 from the AW handshake until the B handshake.
- R11: Write transactions and their data do not change the buffered words or the read sequence.
- R12: After reset: sReady = 1, arReady = 1, awReady = 1, rValid = 0, bValid = 0 and burstAvail = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sValid | input | 1 | Stream word offered |
| sReady | output | 1 | Stream word can be taken |
| sData | input | 32 | Stream word |
| burstAvail | output | 1 | At least 16 words buffered |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arId | input | 4 | Read transaction ID |
| arLen | input | 8 | Read beats minus one |
| rValid | output | 1 | Read beat valid |
| rReady | input | 1 | Read beat ready |
| rId | output | 4 | Read beat ID |
| rData | output | 32 | Read beat data |
| rResp | output | 2 | Read response, always OKAY |
| rLast | output | 1 | Final beat of the read |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| awId | input | 4 | Write transaction ID |
| wValid | input | 1 | Write beat valid |
| wReady | output | 1 | Write beat ready |
| wData | input | 32 | Write data, discarded |
| wLast | input | 1 | Final write beat |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bId | output | 4 | Write response ID |
| bResp | output | 2 | Write response, always OKAY |

## Verification
A word pushed at a rising edge raises the FIFO count at that same edge. burstAvail and sReady follow from that count, so they are valid one cycle after the crossing handshake. The first read beat is due one cycle after the AR handshake when the FIFO holds data. Each later beat is due in the cycle after the previous beat's handshake. bValid comes one cycle after the data beat that carries wLast. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which lies after every register on the path has taken its rising-edge update. When a beat may wait on data, the bench polls rValid at falling edges instead of assuming a fixed delay.

// File: rtl/sab_pkg.sv
package sab_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic pop;
  } ctrlStrobeT;

  typedef struct packed {
    logic empty;
  } dpStatusT;

  typedef enum logic {RD_IDLE, RD_BEAT} rdStateT;
  typedef enum logic [1:0] {WR_ADDR, WR_DATA, WR_RESP} wrStateT;
endpackage

// File: rtl/sab_datapath.sv
module sab_datapath
  import sab_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 64,   // power of two
  parameter int BURST_BEATS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  ctrlStrobeT        strobe,
  output dpStatusT          status,
  output logic [DATA_W-1:0] headData,
  output logic              burstAvail
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] BURST_CNT = CNT_W'(BURST_BEATS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop, isEmpty;

  assign isEmpty = (count == '0);
  assign sReady  = (count != FULL_CNT);
  assign push    = sValid && sReady;
  assign pop     = strobe.pop && !isEmpty;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= sData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData     = mem[rdPtr];
  assign status.empty = isEmpty;
  assign burstAvail   = (count >= BURST_CNT);
endmodule

// File: rtl/sab_control.sv
module sab_control
  import sab_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStatusT         status,
  output ctrlStrobeT       strobe,
  input  logic             arValid,
  output logic             arReady,
  input  logic [ID_W-1:0]  arId,
  input  logic [LEN_W-1:0] arLen,
  output logic             rValid,
  input  logic             rReady,
  output logic [ID_W-1:0]  rId,
  output logic [1:0]       rResp,
  output logic             rLast,
  input  logic             awValid,
  output logic             awReady,
  input  logic [ID_W-1:0]  awId,
  input  logic             wValid,
  output logic             wReady,
  input  logic             wLast,
  output logic             bValid,
  input  logic             bReady,
  output logic [ID_W-1:0]  bId,
  output logic [1:0]       bResp
);
  rdStateT          rdState;
  wrStateT          wrState;
  logic [LEN_W-1:0] beatsLeft;
  logic [ID_W-1:0]  rIdQ, bIdQ;

  // read side: one transaction, beats gated by FIFO occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState   <= RD_IDLE;
      beatsLeft <= '0;
      rIdQ      <= '0;
    end else begin
      case (rdState)
        RD_IDLE: if (arValid) begin
          rIdQ      <= arId;
          beatsLeft <= arLen;
          rdState   <= RD_BEAT;
        end
        RD_BEAT: if (rValid && rReady) begin
          if (beatsLeft == '0) rdState <= RD_IDLE;
          else                 beatsLeft <= beatsLeft - 1'b1;
        end
        default: rdState <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    arReady    = (rdState == RD_IDLE);
    rValid     = (rdState == RD_BEAT) && !status.empty;
    rLast      = (beatsLeft == '0);
    rId        = rIdQ;
    rResp      = RESP_OKAY;
    strobe.pop = rValid && rReady;
  end

  // write side: accept and discard, then answer OKAY
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState <= WR_ADDR;
      bIdQ    <= '0;
    end else begin
      case (wrState)
        WR_ADDR: if (awValid) begin
          bIdQ    <= awId;
          wrState <= WR_DATA;
        end
        WR_DATA: if (wValid && wLast) wrState <= WR_RESP;
        WR_RESP: if (bReady) wrState <= WR_ADDR;
        default: wrState <= WR_ADDR;
      endcase
    end
  end

  always_comb begin
    awReady = (wrState == WR_ADDR);
    wReady  = (wrState == WR_DATA);
    bValid  = (wrState == WR_RESP);
    bId     = bIdQ;
    bResp   = RESP_OKAY;
  end
endmodule

// File: rtl/stream_axi_rd_bridge.sv
module stream_axi_rd_bridge
  import sab_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ID_W        = 4,
  parameter int LEN_W       = 8,
  parameter int DEPTH       = 64,
  parameter int BURST_BEATS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  output logic              burstAvail,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ID_W-1:0]   arId,
  input  logic [LEN_W-1:0]  arLen,
  output logic              rValid,
  input  logic              rReady,
  output logic [ID_W-1:0]   rId,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rLast,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ID_W-1:0]   awId,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wLast,
  output logic              bValid,
  input  logic              bReady,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp
);
  ctrlStrobeT strobe;
  dpStatusT   status;

  sab_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST_BEATS(BURST_BEATS)) uDp (
    .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .sData(sData),
    .strobe(strobe), .status(status), .headData(rData), .burstAvail(burstAvail)
  );

  sab_control #(.ID_W(ID_W), .LEN_W(LEN_W)) uCtl (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rResp(rResp), .rLast(rLast),
    .awValid(awValid), .awReady(awReady), .awId(awId),
    .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bId(bId), .bResp(bResp)
  );
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
  parameter int DATA_W      = 32,
  parameter int ID_W        = 4,
  parameter int LEN_W       = 8,
  parameter int DEPTH       = 64,
  parameter int BURST_BEATS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sValid,
  input logic              sReady,
  input logic              burstAvail,
  input logic              arValid,
  input logic              arReady,
  input logic [ID_W-1:0]   arId,
  input logic [LEN_W-1:0]  arLen,
  input logic              rValid,
  input logic              rReady,
  input logic [ID_W-1:0]   rId,
  input logic [DATA_W-1:0] rData,
  input logic [1:0]        rResp,
  input logic              rLast,
  input logic              awValid,
  input logic              awReady,
  input logic [ID_W-1:0]   awId,
  input logic              wValid,
  input logic [DATA_W-1:0] wData,
  input logic              bValid,
  input logic [ID_W-1:0]   bId,
  input logic [1:0]        bResp
);
  localparam int CNT_W = $clog2(DEPTH) + 2;

  logic [CNT_W-1:0] occ;
  logic [LEN_W-1:0] lenQ, beatIdx;
  logic [ID_W-1:0]  arIdQ, awIdQ;
  logic             pushHs, popHs;

  assign pushHs = sValid && sReady;
  assign popHs  = rValid && rReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ <= '0; lenQ <= '0; beatIdx <= '0; arIdQ <= '0; awIdQ <= '0;
    end else begin
      occ <= occ + CNT_W'(pushHs) - CNT_W'(popHs);
      if (arValid && arReady) begin
        lenQ <= arLen; arIdQ <= arId; beatIdx <= '0;
      end else if (popHs) begin
        beatIdx <= beatIdx + 1'b1;
      end
      if (awValid && awReady) awIdQ <= awId;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH)) else $error("fifo overflow"); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !sReady) else $error("ready while full"); // R8
  AST_BURST_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    burstAvail == (occ >= CNT_W'(BURST_BEATS))) else $error("burst level"); // R7
  AST_NO_EMPTY_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (occ != '0)) else $error("beat from empty fifo"); // R9
  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rLast == (beatIdx == lenQ))) else $error("rLast position"); // R3
  AST_RID_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rId == arIdQ && rResp == 2'b00)) else $error("rId/rResp"); // R4
  AST_AR_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> !arReady) else $error("arReady during read"); // R10
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData))) else $error("beat dropped"); // R1
  AST_B_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> (bId == awIdQ && bResp == 2'b00 && !awReady)) else $error("B response"); // R6
  AST_WDATA_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> !$isunknown(wData)) else $error("unknown write data"); // R11
endmodule

bind stream_axi_rd_bridge sab_checker #(
  .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .BURST_BEATS(BURST_BEATS)
) uChk (
  .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .burstAvail(burstAvail),
  .arValid(arValid), .arReady(arReady), .arId(arId), .arLen(arLen),
  .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData), .rResp(rResp), .rLast(rLast),
  .awValid(awValid), .awReady(awReady), .awId(awId), .wValid(wValid), .wData(wData),
  .bValid(bValid), .bId(bId), .bResp(bResp)
);

// File: tb/sim_stream_axi_rd_bridge.sv
module sim_stream_axi_rd_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        sValid = 1'b0, sReady;
  logic [31:0] sData = '0;
  logic        burstAvail;
  logic        arValid = 1'b0, arReady;
  logic [3:0]  arId = '0;
  logic [7:0]  arLen = '0;
  logic        rValid, rReady = 1'b0, rLast;
  logic [3:0]  rId;
  logic [31:0] rData;
  logic [1:0]  rResp;
  logic        awValid = 1'b0, awReady;
  logic [3:0]  awId = '0;
  logic        wValid = 1'b0, wReady, wLast = 1'b0;
  logic [31:0] wData = '0;
  logic        bValid, bReady = 1'b0;
  logic [3:0]  bId;
  logic [1:0]  bResp;

  int checks = 0, errors = 0;
  int pushSeq = 0, popSeq = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_axi_rd_bridge u0 (
    .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .sData(sData),
    .burstAvail(burstAvail), .arValid(arValid), .arReady(arReady), .arId(arId),
    .arLen(arLen), .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData),
    .rResp(rResp), .rLast(rLast), .awValid(awValid), .awReady(awReady), .awId(awId),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bId(bId), .bResp(bResp)
  );

  function automatic logic [31:0] wordOf(input int n);
    return 32'h5A00_0000 | 32'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      sValid = 1'b1;
      sData  = wordOf(pushSeq);
      while (!sReady) @(negedge clk);
      @(negedge clk);
      pushSeq++;
    end
    sValid = 1'b0;
  endtask

  task automatic readTxn(input logic [3:0] id, input logic [7:0] len, input string req);
    chk(arReady == 1'b1, "R10 arReady idle", 32'(arReady), 1);
    arValid = 1'b1; arId = id; arLen = len;
    @(negedge clk);
    arValid = 1'b0;
    rReady  = 1'b1;
    for (int b = 0; b <= int'(len); b++) begin
      while (!rValid) @(negedge clk);
      chk(rData == wordOf(popSeq), req, rData, wordOf(popSeq));
      chk(rLast == (b == int'(len)), "R3/R5 rLast", 32'(rLast), 32'(b == int'(len)));
      chk(rId == id && rResp == 2'b00, "R4 rId/rResp", {rId, 26'd0, rResp}, {id, 28'd0});
      chk(arReady == 1'b0, "R10 arReady busy", 32'(arReady), 0);
      @(negedge clk);
      popSeq++;
    end
    rReady = 1'b0;
  endtask

  task automatic writeTxn(input logic [3:0] id, input int beats);
    chk(awReady == 1'b1, "R6 awReady idle", 32'(awReady), 1);
    awValid = 1'b1; awId = id;
    @(negedge clk);
    awValid = 1'b0;
    for (int b = 0; b < beats; b++) begin
      wValid = 1'b1;
      wData  = 32'hFFFF_0000 + 32'(b);
      wLast  = (b == beats - 1);
      while (!wReady) @(negedge clk);
      @(negedge clk);
    end
    wValid = 1'b0; wLast = 1'b0;
    chk(awReady == 1'b0, "R10 awReady busy", 32'(awReady), 0);
    chk(bValid == 1'b1, "R6 bValid after wLast", 32'(bValid), 1);
    chk(bId == id && bResp == 2'b00, "R6 bId/bResp", {bId, 26'd0, bResp}, {id, 28'd0});
    bReady = 1'b1;
    @(negedge clk);
    bReady = 1'b0;
    chk(bValid == 1'b0, "R6 single B", 32'(bValid), 0);
    chk(awReady == 1'b1, "R10 awReady reopened", 32'(awReady), 1);
  endtask

  task automatic testReset();
    chk(sReady && arReady && awReady, "R12 readies", {sReady, arReady, awReady}, 3'b111);
    chk(!rValid && !bValid && !burstAvail, "R12 idle outputs", {rValid, bValid, burstAvail}, 0);
  endtask

  task automatic testBurstLevel();
    pushWords(15);
    chk(burstAvail == 1'b0, "R7 15 words", 32'(burstAvail), 0);
    pushWords(1);
    chk(burstAvail == 1'b1, "R7 16 words", 32'(burstAvail), 1);
  endtask

  task automatic testBurstRead();
    readTxn(4'h3, 8'd15, "R2 burst order");
    chk(burstAvail == 1'b0, "R7 drained", 32'(burstAvail), 0);
  endtask

  task automatic testEmptyRead();
    arValid = 1'b1; arId = 4'h9; arLen = 8'd0;
    @(negedge clk);
    arValid = 1'b0; rReady = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk(rValid == 1'b0, "R9 empty holds rValid", 32'(rValid), 0);
      chk(arReady == 1'b0, "R10 arReady while waiting", 32'(arReady), 0);
      @(negedge clk);
    end
    sValid = 1'b1; sData = wordOf(pushSeq);
    @(negedge clk);
    sValid = 1'b0; pushSeq++;
    chk(rValid == 1'b1, "R9 beat after arrival", 32'(rValid), 1);
    chk(rData == wordOf(popSeq), "R9 data", rData, wordOf(popSeq));
    chk(rLast && rId == 4'h9, "R5 single last", {rLast, rId}, {1'b1, 4'h9});
    @(negedge clk);
    popSeq++; rReady = 1'b0;
    chk(arReady == 1'b1, "R10 arReady after last", 32'(arReady), 1);
  endtask

  task automatic testSingles();
    pushWords(10);
    for (int i = 0; i < 10; i++) readTxn(4'(i), 8'd0, "R5 single order");
  endtask

  task automatic testWriteIgnored();
    pushWords(4);
    writeTxn(4'hC, 16);
    writeTxn(4'h5, 1);
    for (int i = 0; i < 4; i++) readTxn(4'h1, 8'd0, "R11 order after writes");
  endtask

  task automatic testFull();
    pushWords(64);
    chk(sReady == 1'b0, "R8 full", 32'(sReady), 0);
    sValid = 1'b1; sData = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sReady == 1'b0, "R8 stays full", 32'(sReady), 0);
    end
    sValid = 1'b0;
    for (int k = 0; k < 4; k++) readTxn(4'(k + 2), 8'd15, "R1/R8 order after full");
    chk(burstAvail == 1'b0 && sReady, "R8 drained", {burstAvail, sReady}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBurstLevel();
    testBurstRead();
    testEmptyRead();
    testSingles();
    testWriteIgnored();
    testFull();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule